// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five localities (numbered 0 to 4) owns a security module's register interface at any moment. Each locality has a byte-wide access register, reached through a locality select together with read and write strobes. Software writes a request bit to ask for ownership on behalf of a locality. The owner writes the active bit to give ownership back. While the interface is free, the arbiter grants the highest-numbered waiting locality.

The block reports the owner as a one-hot vector and as a valid flag with an index. It also qualifies downstream accesses: an access to the status or FIFO registers is passed on only when it comes from the owning locality. Bus decoding, interrupts and the command engine sit outside this block.

Top module: `loc_access_arbiter`

## Requirements
- R1: After a synchronous active-high reset, no locality owns the interface and no request is pending, so every valid locality's register reads 0x80.
- R2: While `acc_rd` is high and `acc_sel` is 0..4, `acc_rdata` has bit 7 set to 1, bit 5 set when the selected locality owns the interface, bit 1 set when it has a pending request, and all other bits 0. When `acc_rd` is low or `acc_sel` is 5..7, `acc_rdata` is 0x00.
- R3: A write with bit 1 set and bit 5 clear to a locality that does not own the interface marks a pending request for it from the next clock edge.
- R4: At a clock edge where no locality owns the interface and at least one request is pending, ownership goes to the highest-numbered pending locality, and that locality's pending request is cleared.
- R5: A request write from the locality that already owns the interface has no effect. The owner never has a pending request.
- R6: A write with bit 5 set from the owning locality frees the interface at the next clock edge. Requests that are still pending are then granted at the edge after that.
- R7: A write with bit 5 set from a locality that does not own the interface leaves ownership unchanged and clears that locality's pending request. When bit 5 is set, bit 1 of the same write is ignored.
- R8: `active_onehot` has at most one bit set. That bit is at index `owner_id` exactly when `owner_valid` is 1.
- R9: `dn_ok` is 1 exactly when `dn_req` is 1 and `dn_sel` names the owning locality.
- R10: A write with `acc_sel` of 5, 6 or 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel | input | 3 | Locality whose access register is addressed |
| acc_wr | input | 1 | Write strobe for the access register |
| acc_rd | input | 1 | Read strobe for the access register |
| acc_wdata | input | 8 | Write data (bit 5 relinquish, bit 1 request) |
| acc_rdata | output | 8 | Read data of the selected access register |
| dn_req | input | 1 | Downstream status/FIFO access strobe |
| dn_sel | input | 3 | Locality issuing the downstream access |
| dn_ok | output | 1 | Downstream access is allowed through |
| active_onehot | output | 5 | One-hot owner vector |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_id | output | 3 | Index of the owning locality |

## Verification
`acc_rdata` and `dn_ok` are combinational in the current state, so the bench compares them in the same cycle they are driven, one nanosecond before the clock edge. A write registers its pending or release effect at the next edge. A grant lands one edge after that, so a request to a free interface shows ownership two edges after the write. The bench drives on the falling edge, updates its reference model at the rising edge together with the design, and compares the state outputs in the next cycle. Directed steps also check literal register values at these cycle points.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    localparam int NUM_LOC     = 5;
    localparam int LOC_W       = 3;
    localparam int REG_W       = 8;
    localparam int BIT_VALID   = 7;
    localparam int BIT_ACTIVE  = 5;
    localparam int BIT_REQUEST = 1;

    typedef struct packed {
        logic             valid;
        logic [LOC_W-1:0] id;
    } owner_t;

    typedef struct packed {
        logic             hit;
        logic [LOC_W-1:0] sel;
        logic             want_req;
        logic             want_rel;
    } acc_wr_t;

    function automatic logic [REG_W-1:0] pack_reg(input logic is_owner, input logic is_pending);
        logic [REG_W-1:0] r;
        r              = '0;
        r[BIT_VALID]   = 1'b1;
        r[BIT_ACTIVE]  = is_owner;
        r[BIT_REQUEST] = is_pending;
        return r;
    endfunction

endpackage

// File: rtl/loc_req_tracker.sv
module loc_req_tracker
    import loc_arb_pkg::*;
#(
    parameter int N = NUM_LOC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] grant_vec,
    output logic [N-1:0] pending
);

    logic [N-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | set_vec) & ~clr_vec & ~grant_vec;
        end
    end

    assign pending = pend_q;

    // R4: a granted locality loses its pending request
    assert_grant_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (|grant_vec) |=> ((pending & $past(grant_vec)) == '0));

    // R3: a surviving set shows up as pending at the next edge
    assert_set_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & ~clr_vec & ~grant_vec)) |=>
        ((pending & $past(set_vec & ~clr_vec & ~grant_vec)) == $past(set_vec & ~clr_vec & ~grant_vec)));

    // R7: a clear removes the pending request
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (|clr_vec) |=> ((pending & $past(clr_vec)) == '0));

endmodule

// File: rtl/loc_owner_ctrl.sv
module loc_owner_ctrl
    import loc_arb_pkg::*;
#(
    parameter int N = NUM_LOC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pending,
    input  logic         release_req,
    output owner_t       owner,
    output logic [N-1:0] grant_vec
);

    owner_t           owner_q;
    logic [LOC_W-1:0] top_id;
    logic             grant_en;

    always_comb begin
        top_id = '0;
        for (int i = 0; i < N; i++) begin
            if (pending[i]) top_id = LOC_W'(i);
        end
    end

    assign grant_en  = !owner_q.valid && (|pending);
    assign grant_vec = grant_en ? (N'(1) << top_id) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= '0;
        end else if (release_req) begin
            owner_q.valid <= 1'b0;
        end else if (grant_en) begin
            owner_q.valid <= 1'b1;
            owner_q.id    <= top_id;
        end
    end

    assign owner = owner_q;

    // R4: grant goes to the highest pending locality
    assert_grant_top_R4: assert property (@(posedge clk) disable iff (rst)
        (!owner_q.valid && (|pending)) |=>
        (owner_q.valid && (($past(pending) >> owner_q.id) == N'(1))));

    // R6: a release frees the interface at the next edge
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        release_req |=> !owner_q.valid);

    // R6: ownership holds while no release arrives
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (owner_q.valid && !release_req) |=> $stable(owner_q));

endmodule

// File: rtl/loc_access_gate.sv
module loc_access_gate
    import loc_arb_pkg::*;
#(
    parameter int N = NUM_LOC
) (
    input  owner_t           owner,
    input  logic [N-1:0]     pending,
    input  logic             acc_rd,
    input  logic [LOC_W-1:0] acc_sel,
    input  logic             dn_req,
    input  logic [LOC_W-1:0] dn_sel,
    output logic [REG_W-1:0] acc_rdata,
    output logic             dn_ok,
    output logic [N-1:0]     active_onehot
);

    logic sel_ok;
    logic sel_owner;
    logic sel_pend;

    for (genvar g = 0; g < N; g++) begin : g_act
        assign active_onehot[g] = owner.valid && (owner.id == LOC_W'(g));
    end

    assign sel_ok    = acc_sel < LOC_W'(N);
    assign sel_owner = |(active_onehot & (N'(1) << acc_sel));
    assign sel_pend  = |(pending & (N'(1) << acc_sel));

    always_comb begin
        acc_rdata = '0;
        if (acc_rd && sel_ok) begin
            acc_rdata = pack_reg(sel_owner, sel_pend);
        end
    end

    assign dn_ok = dn_req && owner.valid && (owner.id == dn_sel);

endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
    import loc_arb_pkg::*;
#(
    parameter int N = NUM_LOC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOC_W-1:0] acc_sel,
    input  logic             acc_wr,
    input  logic             acc_rd,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    input  logic             dn_req,
    input  logic [LOC_W-1:0] dn_sel,
    output logic             dn_ok,
    output logic [N-1:0]     active_onehot,
    output logic             owner_valid,
    output logic [LOC_W-1:0] owner_id
);

    acc_wr_t      wr;
    owner_t       owner;
    logic [N-1:0] pending;
    logic [N-1:0] grant_vec;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;
    logic         sel_is_owner;
    logic         release_req;

    assign wr.hit      = acc_wr && (acc_sel < LOC_W'(N));
    assign wr.sel      = acc_sel;
    assign wr.want_rel = acc_wdata[BIT_ACTIVE];
    assign wr.want_req = acc_wdata[BIT_REQUEST] && !acc_wdata[BIT_ACTIVE];

    assign sel_is_owner = owner.valid && (owner.id == wr.sel);
    assign release_req  = wr.hit && wr.want_rel && sel_is_owner;

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign set_vec[g] = wr.hit && (wr.sel == LOC_W'(g)) && wr.want_req && !sel_is_owner;
        assign clr_vec[g] = wr.hit && (wr.sel == LOC_W'(g)) && wr.want_rel;
    end

    loc_req_tracker #(.N(N)) u_track (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .grant_vec (grant_vec),
        .pending   (pending)
    );

    loc_owner_ctrl #(.N(N)) u_owner (
        .clk         (clk),
        .rst         (rst),
        .pending     (pending),
        .release_req (release_req),
        .owner       (owner),
        .grant_vec   (grant_vec)
    );

    loc_access_gate #(.N(N)) u_gate (
        .owner         (owner),
        .pending       (pending),
        .acc_rd        (acc_rd),
        .acc_sel       (acc_sel),
        .dn_req        (dn_req),
        .dn_sel        (dn_sel),
        .acc_rdata     (acc_rdata),
        .dn_ok         (dn_ok),
        .active_onehot (active_onehot)
    );

    assign owner_valid = owner.valid;
    assign owner_id    = owner.id;

    // R8: at most one active locality, matching the reported owner
    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active_onehot) && (owner_valid == (|active_onehot)));

    // R5: the owner never carries a pending request
    assert_owner_no_pend_R5: assert property (@(posedge clk) disable iff (rst)
        owner_valid |-> ((pending & (N'(1) << owner_id)) == '0));

    // R9: a passed downstream access comes from the active locality
    assert_dn_owner_R9: assert property (@(posedge clk) disable iff (rst)
        dn_ok |-> ((active_onehot & (N'(1) << dn_sel)) != '0));

    // R10: an out-of-range write leaves pending state untouched
    assert_bad_sel_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && (acc_sel >= LOC_W'(N)) && !(|grant_vec)) |=> $stable(pending));

endmodule

// File: tb/loc_access_arbiter_tb.sv
module loc_access_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] acc_sel = '0;
    logic       acc_wr = 1'b0;
    logic       acc_rd = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       dn_req = 1'b0;
    logic [2:0] dn_sel = '0;
    logic       dn_ok;
    logic [4:0] active_onehot;
    logic       owner_valid;
    logic [2:0] owner_id;

    int total = 0;
    int bad   = 0;

    logic [4:0] m_pend;
    logic       m_ov;
    logic [2:0] m_oid;

    always #5 clk = ~clk;

    loc_access_arbiter dut_i (
        .clk (clk), .rst (rst),
        .acc_sel (acc_sel), .acc_wr (acc_wr), .acc_rd (acc_rd),
        .acc_wdata (acc_wdata), .acc_rdata (acc_rdata),
        .dn_req (dn_req), .dn_sel (dn_sel), .dn_ok (dn_ok),
        .active_onehot (active_onehot), .owner_valid (owner_valid), .owner_id (owner_id)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [2:0] s, input logic r);
        logic [7:0] v;
        v = 8'h00;
        if (r && s < 3'd5) begin
            v[7] = 1'b1;
            v[5] = m_ov && (m_oid == s);
            v[1] = m_pend[s];
        end
        return v;
    endfunction

    function automatic logic [4:0] exp_onehot();
        return m_ov ? (5'd1 << m_oid) : 5'd0;
    endfunction

    task automatic model_edge(input logic r, input logic [2:0] s, input logic w, input logic [7:0] d);
        logic [4:0] np;
        logic       nv;
        logic [2:0] ni;
        logic       grant;
        logic [2:0] hi;
        np = m_pend; nv = m_ov; ni = m_oid;
        grant = !m_ov && (m_pend != 0);
        hi = 3'd0;
        for (int i = 0; i < 5; i++) if (m_pend[i]) hi = 3'(i);
        if (w && s < 3'd5) begin
            if (d[5]) begin
                if (m_ov && m_oid == s) nv = 1'b0;
                else np[s] = 1'b0;
            end else if (d[1] && !(m_ov && m_oid == s)) begin
                np[s] = 1'b1;
            end
        end
        if (grant) begin
            nv = 1'b1; ni = hi; np[hi] = 1'b0;
        end
        if (r) begin
            np = '0; nv = 1'b0; ni = '0;
        end
        m_pend = np; m_ov = nv; m_oid = ni;
    endtask

    // Called at a falling edge; checks just before the next rising edge.
    task automatic cyc(input logic [2:0] s, input logic w, input logic r, input logic [7:0] d,
                       input logic q, input logic [2:0] qs);
        acc_sel = s; acc_wr = w; acc_rd = r; acc_wdata = d; dn_req = q; dn_sel = qs;
        #4;
        if (!rst) begin
            chk(acc_rdata == exp_rdata(s, r), "R2 rdata", acc_rdata, exp_rdata(s, r));
            chk(active_onehot == exp_onehot(), "R8 onehot", active_onehot, exp_onehot());
            chk(owner_valid == m_ov, "R4 owner_valid", owner_valid, m_ov);
            if (m_ov) chk(owner_id == m_oid, "R4 owner_id", owner_id, m_oid);
            chk(dn_ok == (q && m_ov && m_oid == qs), "R9 dn_ok", dn_ok, q && m_ov && m_oid == qs);
        end
        @(posedge clk);
        model_edge(rst, s, w, d);
        @(negedge clk);
    endtask

    task automatic rd_lit(input logic [2:0] s, input logic [7:0] exp, input string tag);
        acc_sel = s; acc_wr = 1'b0; acc_rd = 1'b1; acc_wdata = '0; dn_req = 1'b0;
        #4;
        chk(acc_rdata == exp, tag, acc_rdata, exp);
        @(posedge clk);
        model_edge(rst, s, 1'b0, 8'h00);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        logic [7:0] d;
        seed = $urandom(32'd7321);
        m_pend = '0; m_ov = 1'b0; m_oid = '0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
        rst = 1'b0;

        // R1: reset state
        for (int l = 0; l < 5; l++) rd_lit(3'(l), 8'h80, "R1 reset reg");
        chk(owner_valid == 1'b0, "R1 owner_valid", owner_valid, 0);
        chk(active_onehot == 5'd0, "R1 onehot", active_onehot, 0);

        // R3/R4: request to free interface
        cyc(3'd0, 1'b1, 1'b0, 8'h02, 1'b0, 3'd0);
        rd_lit(3'd0, 8'h82, "R3 pending shown");
        rd_lit(3'd0, 8'hA0, "R4 granted 0");

        // R3: several pending while locality 0 owns
        cyc(3'd2, 1'b1, 1'b0, 8'h02, 1'b0, 3'd0);
        cyc(3'd4, 1'b1, 1'b0, 8'h02, 1'b0, 3'd0);
        cyc(3'd1, 1'b1, 1'b0, 8'h02, 1'b0, 3'd0);
        rd_lit(3'd4, 8'h82, "R3 pending 4");

        // R5: owner request ignored
        cyc(3'd0, 1'b1, 1'b0, 8'h02, 1'b0, 3'd0);
        rd_lit(3'd0, 8'hA0, "R5 owner unchanged");

        // R10: out-of-range writes ignored
        cyc(3'd6, 1'b1, 1'b0, 8'h22, 1'b0, 3'd0);
        cyc(3'd5, 1'b1, 1'b0, 8'h02, 1'b0, 3'd0);
        rd_lit(3'd6, 8'h00, "R10 bad sel read");
        rd_lit(3'd0, 8'hA0, "R10 owner kept");
        rd_lit(3'd2, 8'h82, "R10 pending kept");

        // R7: non-owner relinquish clears its pending only
        cyc(3'd2, 1'b1, 1'b0, 8'h20, 1'b0, 3'd0);
        rd_lit(3'd2, 8'h80, "R7 pending cleared");
        rd_lit(3'd0, 8'hA0, "R7 owner kept");
        cyc(3'd1, 1'b1, 1'b0, 8'h22, 1'b0, 3'd0);
        rd_lit(3'd1, 8'h80, "R7 both bits");

        // R9: downstream gating while 0 owns
        cyc(3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd0);
        chk(1'b1, "R9 directed", 0, 0);
        cyc(3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd4);

        // R6: owner release, then highest pending granted
        cyc(3'd0, 1'b1, 1'b0, 8'h20, 1'b0, 3'd0);
        rd_lit(3'd4, 8'h82, "R6 interface free");
        chk(owner_valid == 1'b1 && owner_id == 3'd4, "R4 top grant", owner_id, 4);
        rd_lit(3'd4, 8'hA0, "R6 granted 4");

        // Random traffic against the model
        for (int k = 0; k < 600; k++) begin
            case ($urandom_range(0, 4))
                0: d = 8'h02;
                1: d = 8'h20;
                2: d = 8'h22;
                3: d = 8'h02;
                default: d = 8'($urandom);
            endcase
            cyc(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d,
                1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule